// File: doc/BRIEF.md
# Extended Next-PC and Branch Unit

This combinational unit picks the address of the next instruction for a 32-bit single-cycle core. It also decides whether the retiring instruction writes a return address. It takes the current PC, the instruction word, the value read from source register rs, the zero and negative flags of a status register that is loaded every cycle, and the word that data memory returns for this instruction. From these it chooses one of five targets:

- the sequential address PC+4
- a PC-relative branch target
- a pseudo-direct jump target
- a register target
- a target loaded from memory

The unit handles four groups of instructions. Sign tests compare rs with zero. Flag-gated branches go to rs or to a pseudo-direct target. The jump-and-link form always jumps. Indirect jumps take their target from the memory word. The memory address for an indirect jump is rs plus the immediate or the stack pointer, and the surrounding datapath forms it. When a link is required, the unit raises either a register-file write (with the destination number) or a memory write for the stack-pushing form. In both cases the value to store is PC+4.

Top module: `npc_unit`

## Requirements
- R1: Any instruction not listed in R2 to R9 gives next_pc = PC+4, link_we = 0, link_mem_we = 0 and link_reg = 0. This includes R-type (opcode 0) with funct other than 20, 21 or 22. link_val always equals PC+4.
- R2: Opcodes 1, 38 and 39 branch when rs is negative, strictly positive, or non-negative respectively, with rs read as two's complement. The taken target is PC+4 + (sign-extended instr[15:0] << 2). A branch that is not taken gives PC+4. None of the three writes a link.
- R3: Opcode 35 branches like opcode 39. It sets link_we with link_reg = 31 only when taken, and gives no link when not taken.
- R4: R-type funct 20 jumps to rs when Z = 1, and funct 21 jumps to rs when N = 1. Otherwise both give PC+4 with no link.
- R5: R-type funct 22 jumps to rs when Z = 1 and links into rd (instr[15:11]). A zero rd field selects register 31. When Z = 0 there is no jump and no link.
- R6: Opcodes 24 and 26 jump to {PC+4[31:28], instr[25:0], 2'b00} when Z = 1. Opcode 26 also links into register 31, and only when taken.
- R7: Opcode 3 always jumps to the pseudo-direct target and links into register 31, whatever the flags.
- R8: Opcodes 16 and 17 jump to mem_rdata. Opcode 17 links into rt (instr[20:16]), and a zero rt field selects register 31.
- R9: Opcodes 18 and 19 jump to mem_rdata. Opcode 19 sets link_mem_we and leaves link_we at 0. link_we and link_mem_we are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current PC |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of register rs |
| flag_z_i | input | 1 | Registered status zero flag |
| flag_n_i | input | 1 | Registered status negative flag |
| mem_rdata_i | input | 32 | Word read from data memory for this instruction |
| next_pc_o | output | 32 | Address of the next instruction |
| link_we_o | output | 1 | Register-file link write enable |
| link_reg_o | output | 5 | Link destination register number |
| link_val_o | output | 32 | Link value (PC+4) |
| link_mem_we_o | output | 1 | Request to store the link value in memory |

## Verification
The bench targets the sign tests at their edges:

- rs equal to zero must go one way for the strictly-positive test and the other way for the non-negative test.
- The most negative value must not count as positive. A design that compared unsigned, or that used >= where > belongs, would branch on the wrong side.

Linking forms are driven both taken and not taken. This exposes a unit that writes a return address whenever the opcode matches. Zero rd and rt fields are applied to catch a link that lands in register 0 instead of 31.

A negative branch offset checks the sign extension. A PC with high bits set checks that the pseudo-direct target keeps PC+4[31:28]. For the stack form, the bench confirms that the memory push is raised while the register write stays low.

// File: rtl/npc_pkg.sv
// Package: shared encodings for the next-PC unit.
// Holds the opcode and funct values that are decoded, the instruction kind
// enumeration, the target-source select and the link mode.
package npc_pkg;

    localparam int OPW = 6;
    localparam int FNW = 6;

    localparam logic [OPW-1:0] OP_RTYPE  = 6'd0;
    localparam logic [OPW-1:0] OP_BLTZ   = 6'd1;
    localparam logic [OPW-1:0] OP_JAL    = 6'd3;
    localparam logic [OPW-1:0] OP_JM     = 6'd16;
    localparam logic [OPW-1:0] OP_JALM   = 6'd17;
    localparam logic [OPW-1:0] OP_JSP    = 6'd18;
    localparam logic [OPW-1:0] OP_JSPAL  = 6'd19;
    localparam logic [OPW-1:0] OP_BZ     = 6'd24;
    localparam logic [OPW-1:0] OP_BALZ   = 6'd26;
    localparam logic [OPW-1:0] OP_BGEZAL = 6'd35;
    localparam logic [OPW-1:0] OP_BGTZ   = 6'd38;
    localparam logic [OPW-1:0] OP_BGEZ   = 6'd39;

    localparam logic [FNW-1:0] FN_BRZ    = 6'd20;
    localparam logic [FNW-1:0] FN_BRN    = 6'd21;
    localparam logic [FNW-1:0] FN_BALRZ  = 6'd22;

    typedef enum logic [3:0] {
        K_SEQ, K_BLTZ, K_BGTZ, K_BGEZ, K_BGEZAL,
        K_BRZ, K_BRN, K_BALRZ, K_BZ, K_BALZ, K_JAL,
        K_JM, K_JALM, K_JSP, K_JSPAL
    } npc_kind_e;

    typedef enum logic [2:0] {
        SRC_SEQ, SRC_REL, SRC_REG, SRC_PD, SRC_MEM
    } npc_src_e;

    typedef enum logic [1:0] {
        LNK_NONE, LNK_REG, LNK_MEM
    } npc_link_e;

endpackage

// File: rtl/npc_decode.sv
// Module: npc_decode
// Maps the opcode and funct fields to one instruction kind.
// Assumes: any encoding not listed decodes to K_SEQ (plain sequential flow).
module npc_decode
    import npc_pkg::*;
(
    input  logic [OPW-1:0] opcode_i,
    input  logic [FNW-1:0] funct_i,
    output npc_kind_e      kind_o
);

    // Classify the instruction by opcode, and by funct for R-type.
    always_comb begin
        kind_o = K_SEQ;
        unique case (opcode_i)
            OP_RTYPE: begin
                unique case (funct_i)
                    FN_BRZ:   kind_o = K_BRZ;
                    FN_BRN:   kind_o = K_BRN;
                    FN_BALRZ: kind_o = K_BALRZ;
                    default:  kind_o = K_SEQ;
                endcase
            end
            OP_BLTZ:   kind_o = K_BLTZ;
            OP_BGTZ:   kind_o = K_BGTZ;
            OP_BGEZ:   kind_o = K_BGEZ;
            OP_BGEZAL: kind_o = K_BGEZAL;
            OP_BZ:     kind_o = K_BZ;
            OP_BALZ:   kind_o = K_BALZ;
            OP_JAL:    kind_o = K_JAL;
            OP_JM:     kind_o = K_JM;
            OP_JALM:   kind_o = K_JALM;
            OP_JSP:    kind_o = K_JSP;
            OP_JSPAL:  kind_o = K_JSPAL;
            default:   kind_o = K_SEQ;
        endcase
    end

endmodule

// File: rtl/npc_cond.sv
// Module: npc_cond
// Evaluates the branch condition for the decoded kind.
// It selects the target source, the link mode and the link register.
// Assumes: rs is two's complement, and the flags are the registered status bits.
// A conditional form that is not taken yields SRC_SEQ and LNK_NONE.
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REGW     = 5,
    parameter int LINK_REG = 31
) (
    input  npc_kind_e        kind_i,
    input  logic [XLEN-1:0]  rs_val_i,
    input  logic             flag_z_i,
    input  logic             flag_n_i,
    input  logic [REGW-1:0]  rd_i,
    input  logic [REGW-1:0]  rt_i,
    output npc_src_e         src_o,
    output npc_link_e        lnk_o,
    output logic [REGW-1:0]  lnk_reg_o
);

    localparam logic [REGW-1:0] RA = REGW'(LINK_REG);

    logic rs_neg, rs_zero;
    assign rs_neg  = rs_val_i[XLEN-1];
    assign rs_zero = (rs_val_i == '0);

    // Choose target source and link behaviour from kind and condition.
    always_comb begin
        src_o     = SRC_SEQ;
        lnk_o     = LNK_NONE;
        lnk_reg_o = '0;
        unique case (kind_i)
            K_BLTZ:  if (rs_neg) src_o = SRC_REL;
            K_BGTZ:  if (!rs_neg && !rs_zero) src_o = SRC_REL;
            K_BGEZ:  if (!rs_neg) src_o = SRC_REL;
            K_BGEZAL: if (!rs_neg) begin
                src_o = SRC_REL; lnk_o = LNK_REG; lnk_reg_o = RA;
            end
            K_BRZ:   if (flag_z_i) src_o = SRC_REG;
            K_BRN:   if (flag_n_i) src_o = SRC_REG;
            K_BALRZ: if (flag_z_i) begin
                src_o = SRC_REG; lnk_o = LNK_REG;
                lnk_reg_o = (rd_i == '0) ? RA : rd_i;
            end
            K_BZ:    if (flag_z_i) src_o = SRC_PD;
            K_BALZ:  if (flag_z_i) begin
                src_o = SRC_PD; lnk_o = LNK_REG; lnk_reg_o = RA;
            end
            K_JAL: begin
                src_o = SRC_PD; lnk_o = LNK_REG; lnk_reg_o = RA;
            end
            K_JM, K_JSP: src_o = SRC_MEM;
            K_JALM: begin
                src_o = SRC_MEM; lnk_o = LNK_REG;
                lnk_reg_o = (rt_i == '0) ? RA : rt_i;
            end
            K_JSPAL: begin
                src_o = SRC_MEM; lnk_o = LNK_MEM;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/npc_target.sv
// Module: npc_target
// Forms the candidate addresses and selects the next PC.
// Assumes: 32-bit words, a 16-bit branch offset and a 26-bit jump index.
module npc_target
    import npc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16,
    parameter int IDXW = 26
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [IMMW-1:0] imm_i,
    input  logic [IDXW-1:0] idx_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    input  npc_src_e        src_i,
    output logic [XLEN-1:0] pc4_o,
    output logic [XLEN-1:0] next_pc_o
);

    localparam int HIW = XLEN - IDXW - 2;

    logic [XLEN-1:0] rel_tgt, pd_tgt, off;

    // Sequential address and the two instruction-encoded targets.
    always_comb begin
        pc4_o   = pc_i + XLEN'(4);
        off     = {{(XLEN-IMMW-2){imm_i[IMMW-1]}}, imm_i, 2'b00};
        rel_tgt = pc4_o + off;
        pd_tgt  = {pc4_o[XLEN-1 -: HIW], idx_i, 2'b00};
    end

    // Select the next PC from the chosen source.
    always_comb begin
        unique case (src_i)
            SRC_REL: next_pc_o = rel_tgt;
            SRC_REG: next_pc_o = rs_val_i;
            SRC_PD:  next_pc_o = pd_tgt;
            SRC_MEM: next_pc_o = mem_rdata_i;
            default: next_pc_o = pc4_o;
        endcase
    end

endmodule

// File: rtl/npc_unit.sv
// Module: npc_unit (top)
// Combinational next-PC and link control for a single-cycle core.
// Assumes: the datapath forms the memory address (rs+imm, or the stack
// pointer) and returns mem_rdata_i in the same cycle. It performs the link
// writes requested here.
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REGW     = 5,
    parameter int LINK_REG = 31
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic            flag_z_i,
    input  logic            flag_n_i,
    input  logic [XLEN-1:0] mem_rdata_i,
    output logic [XLEN-1:0] next_pc_o,
    output logic            link_we_o,
    output logic [REGW-1:0] link_reg_o,
    output logic [XLEN-1:0] link_val_o,
    output logic            link_mem_we_o
);

    npc_kind_e kind;
    npc_src_e  src;
    npc_link_e lnk;
    logic      unused_shamt;

    assign unused_shamt = ^instr_i[10:6];

    npc_decode u_dec (
        .opcode_i (instr_i[31:26]),
        .funct_i  (instr_i[5:0]),
        .kind_o   (kind)
    );

    npc_cond #(.XLEN(XLEN), .REGW(REGW), .LINK_REG(LINK_REG)) u_cond (
        .kind_i    (kind),
        .rs_val_i  (rs_val_i),
        .flag_z_i  (flag_z_i),
        .flag_n_i  (flag_n_i),
        .rd_i      (instr_i[15:11]),
        .rt_i      (instr_i[20:16]),
        .src_o     (src),
        .lnk_o     (lnk),
        .lnk_reg_o (link_reg_o)
    );

    npc_target #(.XLEN(XLEN), .IMMW(16), .IDXW(26)) u_tgt (
        .pc_i        (pc_i),
        .imm_i       (instr_i[15:0]),
        .idx_i       (instr_i[25:0]),
        .rs_val_i    (rs_val_i),
        .mem_rdata_i (mem_rdata_i),
        .src_i       (src),
        .pc4_o       (link_val_o),
        .next_pc_o   (next_pc_o)
    );

    // Turn the link mode into the two write strobes.
    always_comb begin
        link_we_o     = (lnk == LNK_REG);
        link_mem_we_o = (lnk == LNK_MEM);
    end

    // Check strobe exclusivity and target consistency across submodules.
    always_comb begin
        // R9
        link_excl_chk: assert (!(link_we_o && link_mem_we_o));
        // R9
        mem_push_src_chk: assert (!link_mem_we_o || next_pc_o == mem_rdata_i);
        // R5
        link_reg_nz_chk: assert (!link_we_o || link_reg_o != '0);
        // R1
        seq_no_link_chk: assert (src != SRC_SEQ || (!link_we_o && !link_mem_we_o));
    end

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc, instr, rs_val, mem_rdata;
    logic        fz, fn;
    logic [31:0] next_pc, link_val;
    logic        link_we, link_mem_we;
    logic [4:0]  link_reg;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    npc_unit u_npc_unit (
        .pc_i(pc), .instr_i(instr), .rs_val_i(rs_val),
        .flag_z_i(fz), .flag_n_i(fn), .mem_rdata_i(mem_rdata),
        .next_pc_o(next_pc), .link_we_o(link_we), .link_reg_o(link_reg),
        .link_val_o(link_val), .link_mem_we_o(link_mem_we)
    );

    function automatic logic [31:0] i_fmt(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction
    function automatic logic [31:0] r_fmt(input logic [4:0] rd, input logic [5:0] fn_);
        return {6'd0, 5'd9, 5'd0, rd, 5'd0, fn_};
    endfunction
    function automatic logic [31:0] j_fmt(input logic [5:0] op, input logic [25:0] idx);
        return {op, idx};
    endfunction
    function automatic logic [31:0] rel(input logic [31:0] p, input logic [15:0] imm);
        return p + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    endfunction
    function automatic logic [31:0] pdt(input logic [31:0] p, input logic [25:0] idx);
        logic [31:0] p4;
        p4 = p + 32'd4;
        return {p4[31:28], idx, 2'b00};
    endfunction

    // Apply inputs after a rising edge and let them settle to the falling edge.
    task automatic apply(input logic [31:0] p, input logic [31:0] ins, input logic [31:0] rv,
                         input logic z, input logic n, input logic [31:0] md);
        @(posedge clk);
        pc = p; instr = ins; rs_val = rv; fz = z; fn = n; mem_rdata = md;
        @(negedge clk);
    endtask

    // Compare every output against the expected values.
    task automatic expect_all(input string req, input logic [31:0] enpc, input logic ewe,
                              input logic [4:0] ereg, input logic emw);
        n_chk++;
        if (next_pc !== enpc || link_we !== ewe || link_mem_we !== emw ||
            (ewe && link_reg !== ereg) || link_val !== pc + 32'd4) begin
            n_bad++;
            $display("FAIL %s: npc=%h we=%b reg=%0d mw=%b lv=%h exp npc=%h we=%b reg=%0d mw=%b lv=%h",
                     req, next_pc, link_we, link_reg, link_mem_we, link_val,
                     enpc, ewe, ereg, emw, pc + 32'd4);
        end
    endtask

    task automatic t_default;
        apply(32'h0000_1000, i_fmt(6'd8, 5'd1, 5'd2, 16'h0010), 32'h5, 1, 1, 32'hDEAD_0000);
        expect_all("R1 other opcode", 32'h0000_1004, 0, 0, 0);
        n_chk++;
        if (link_reg !== 5'd0) begin
            n_bad++;
            $display("FAIL R1 link_reg=%0d exp 0", link_reg);
        end
        apply(32'h0000_2000, r_fmt(5'd4, 6'd0), 32'h4000, 1, 1, 32'h0);
        expect_all("R1 rtype shift funct", 32'h0000_2004, 0, 0, 0);
    endtask

    task automatic t_sign;
        logic [31:0] p = 32'h0040_0100;
        apply(p, i_fmt(6'd1, 5'd3, 5'd0, 16'h0008), 32'hFFFF_FFFF, 0, 0, 0);
        expect_all("R2 bltz neg", rel(p, 16'h0008), 0, 0, 0);
        apply(p, i_fmt(6'd1, 5'd3, 5'd0, 16'h0008), 32'h0, 0, 0, 0);
        expect_all("R2 bltz zero", p + 4, 0, 0, 0);
        apply(p, i_fmt(6'd38, 5'd3, 5'd0, 16'hFFF0), 32'h0, 0, 0, 0);
        expect_all("R2 bgtz zero", p + 4, 0, 0, 0);
        apply(p, i_fmt(6'd38, 5'd3, 5'd0, 16'hFFF0), 32'h1, 0, 0, 0);
        expect_all("R2 bgtz one neg off", rel(p, 16'hFFF0), 0, 0, 0);
        apply(p, i_fmt(6'd38, 5'd3, 5'd0, 16'h0004), 32'h8000_0000, 0, 0, 0);
        expect_all("R2 bgtz minint", p + 4, 0, 0, 0);
        apply(p, i_fmt(6'd39, 5'd3, 5'd0, 16'h0004), 32'h0, 0, 0, 0);
        expect_all("R2 bgez zero", rel(p, 16'h0004), 0, 0, 0);
        apply(p, i_fmt(6'd39, 5'd3, 5'd0, 16'h0004), 32'h8000_0000, 0, 0, 0);
        expect_all("R2 bgez neg", p + 4, 0, 0, 0);
    endtask

    task automatic t_bgezal;
        logic [31:0] p = 32'h0000_0800;
        apply(p, i_fmt(6'd35, 5'd3, 5'd0, 16'h0010), 32'h7FFF_FFFF, 0, 0, 0);
        expect_all("R3 bgezal taken", rel(p, 16'h0010), 1, 5'd31, 0);
        apply(p, i_fmt(6'd35, 5'd3, 5'd0, 16'h0010), 32'hFFFF_0000, 0, 0, 0);
        expect_all("R3 bgezal not taken", p + 4, 0, 0, 0);
    endtask

    task automatic t_flagreg;
        logic [31:0] p = 32'h0000_3000;
        apply(p, r_fmt(5'd0, 6'd20), 32'h0000_A000, 1, 0, 0);
        expect_all("R4 brz Z=1", 32'h0000_A000, 0, 0, 0);
        apply(p, r_fmt(5'd0, 6'd20), 32'h0000_A000, 0, 1, 0);
        expect_all("R4 brz Z=0", p + 4, 0, 0, 0);
        apply(p, r_fmt(5'd0, 6'd21), 32'h0000_B000, 0, 1, 0);
        expect_all("R4 brn N=1", 32'h0000_B000, 0, 0, 0);
        apply(p, r_fmt(5'd0, 6'd21), 32'h0000_B000, 1, 0, 0);
        expect_all("R4 brn N=0", p + 4, 0, 0, 0);
        apply(p, r_fmt(5'd5, 6'd22), 32'h0000_C000, 1, 0, 0);
        expect_all("R5 balrz rd5", 32'h0000_C000, 1, 5'd5, 0);
        apply(p, r_fmt(5'd0, 6'd22), 32'h0000_C000, 1, 0, 0);
        expect_all("R5 balrz rd0", 32'h0000_C000, 1, 5'd31, 0);
        apply(p, r_fmt(5'd5, 6'd22), 32'h0000_C000, 0, 1, 0);
        expect_all("R5 balrz Z=0", p + 4, 0, 0, 0);
    endtask

    task automatic t_pseudo;
        logic [31:0] p = 32'hA000_0040;
        logic [25:0] ix = 26'h123_4567;
        apply(p, j_fmt(6'd24, ix), 0, 1, 0, 0);
        expect_all("R6 bz Z=1", pdt(p, ix), 0, 0, 0);
        apply(p, j_fmt(6'd24, ix), 0, 0, 1, 0);
        expect_all("R6 bz Z=0", p + 4, 0, 0, 0);
        apply(p, j_fmt(6'd26, ix), 0, 1, 0, 0);
        expect_all("R6 balz Z=1", pdt(p, ix), 1, 5'd31, 0);
        apply(p, j_fmt(6'd26, ix), 0, 0, 0, 0);
        expect_all("R6 balz Z=0", p + 4, 0, 0, 0);
        apply(p, j_fmt(6'd3, ix), 0, 0, 0, 0);
        expect_all("R7 jal", pdt(p, ix), 1, 5'd31, 0);
    endtask

    task automatic t_memind;
        logic [31:0] p = 32'h0000_5000;
        apply(p, i_fmt(6'd16, 5'd4, 5'd9, 16'h0008), 32'h100, 0, 0, 32'h0000_7770);
        expect_all("R8 jm", 32'h0000_7770, 0, 0, 0);
        apply(p, i_fmt(6'd17, 5'd4, 5'd7, 16'h0008), 32'h100, 0, 0, 32'h0000_7780);
        expect_all("R8 jalm rt7", 32'h0000_7780, 1, 5'd7, 0);
        apply(p, i_fmt(6'd17, 5'd4, 5'd0, 16'h0008), 32'h100, 0, 0, 32'h0000_7790);
        expect_all("R8 jalm rt0", 32'h0000_7790, 1, 5'd31, 0);
        apply(p, i_fmt(6'd18, 5'd0, 5'd0, 16'h0), 0, 0, 0, 32'h0000_8800);
        expect_all("R9 jsp", 32'h0000_8800, 0, 0, 0);
        apply(p, i_fmt(6'd19, 5'd0, 5'd0, 16'h0), 0, 0, 0, 32'h0000_8810);
        expect_all("R9 jspal", 32'h0000_8810, 0, 0, 1);
    endtask

    initial begin
        pc = 0; instr = 0; rs_val = 0; fz = 0; fn = 0; mem_rdata = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_default();
        t_sign();
        t_bgezal();
        t_flagreg();
        t_pseudo();
        t_memind();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule